// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block decides which of four DMA channels is served next. Each channel has a raw hardware request line, which may change at any time, a mask bit and a software request bit. The hardware lines pass through a two-stage synchroniser, then through a selectable polarity, and then through their masks. The software bits join after the mask, so a mask never blocks them. When at least one qualified request is pending and the controller is enabled, the block raises a bus hold request and waits for the bus grant.

In the cycle the grant arrives, the block picks one pending channel by priority. The priority is either fixed (lowest index first) or rotating (the channel after the one served last comes first). The winner then stays locked, and its acknowledge line stays active, until the service-done strobe ends the service. When the service ends, the bus is released and the rotation pointer moves to the channel just served. The acknowledge lines can be set to active high or active low. The block produces no addresses and no transfer strobes.

Top module: `dma_chan_arbiter`

## Requirements
- R1: After a synchronous reset, hold_req_o and win_valid_o are 0. With ack_active_high_i=0, all ack_o lines are 1 (inactive). The rotation pointer starts at channel 3, so the first rotating order is 0,1,2,3.
- R2: A change on hw_req_i passes through two synchroniser flops. hold_req_o rises after the third rising edge that follows the change, and not after the second.
- R3: A hardware request whose mask_i bit is 1 is ignored: hold_req_o stays 0 if no other request is pending.
- R4: A software request bit sw_req_i[n]=1 counts as pending whatever the value of mask_i[n]. It is not synchronised, so hold_req_o rises after the next rising edge.
- R5: With rotate_en_i=0, the winner chosen at grant is the lowest-numbered pending channel.
- R6: With rotate_en_i=1, the search starts at the channel after the one served last and wraps around, so the channel just served has the lowest priority. With all four channels requesting, successive services walk through every channel.
- R7: While win_valid_o=1 and done_i=0, the winner stays locked: win_idx_o and ack_o do not change, whatever the requests do.
- R8: With req_active_low_i=1, a hardware line requests when it is low. With req_active_low_i=0, it requests when it is high.
- R9: During service, with ack_active_high_i=1, only the winner's ack_o bit is 1. With ack_active_high_i=0, only the winner's bit is 0.
- R10: While ctrl_disable_i=1, no new hold request starts. A hold request that has not yet been granted is dropped.
- R11: hold_req_o stays 1 from the moment a request is seen until the service ends. After the cycle in which done_i=1 during service, hold_req_o is 0.
- R12: The winner is chosen from the requests pending in the cycle grant_i=1 is seen. If every request goes away before the grant, the hold request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req_i | input | 4 | Raw, asynchronous per-channel hardware requests |
| mask_i | input | 4 | Per-channel mask; 1 blocks the hardware request |
| sw_req_i | input | 4 | Per-channel software requests; a mask does not block them |
| req_active_low_i | input | 1 | 1: hardware requests are active low |
| ack_active_high_i | input | 1 | 1: acknowledges are active high |
| rotate_en_i | input | 1 | 1: rotating priority; 0: fixed priority |
| ctrl_disable_i | input | 1 | 1: no new service may start |
| grant_i | input | 1 | Bus granted; the winner is chosen in this cycle |
| done_i | input | 1 | The current service has ended |
| hold_req_o | output | 1 | Bus hold request |
| win_valid_o | output | 1 | A channel is being served |
| win_idx_o | output | 2 | Index of the channel being served |
| ack_o | output | 4 | Per-channel acknowledge, with programmable polarity |

## Verification
The bench targets the following cases. In each, a wrong design gives a visible symptom:
- The synchroniser latency: a design missing one flop raises the hold request an edge too early.
- The rotation pointer after reset: a pointer that starts at 0 would begin the rotating walk at channel 1 instead of channel 0.
- The lock during service: a design that re-arbitrates live would move the winner when a higher-priority request arrives in mid-service.
- Mask versus software request, together with both polarity controls: each case checks that a masked hardware line raises nothing, that a software bit still wins, and that an inverted sense drives the right acknowledge line.

// File: rtl/arb_pkg.sv
package arb_pkg;
    parameter int unsigned CH_N = 4;
    localparam int unsigned CH_W = $clog2(CH_N);

    typedef logic [CH_N-1:0] ch_vec_t;
    typedef logic [CH_W-1:0] ch_idx_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_SERVE = 2'd2
    } arb_state_e;

    typedef struct packed {
        logic    rotate;
        ch_idx_t last;
    } prio_cfg_t;

    function automatic ch_vec_t idx_to_onehot(ch_idx_t i);
        ch_vec_t v;
        v = '0;
        v[i] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/arb_req_qual.sv
module arb_req_qual
    import arb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ch_vec_t raw_req,
    input  logic    active_low,
    input  ch_vec_t mask,
    input  ch_vec_t sw_req,
    output ch_vec_t pend
);
    ch_vec_t meta_q, sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= raw_req;
            sync_q <= meta_q;
        end
    end

    for (genvar c = 0; c < CH_N; c++) begin : g_qual
        assign pend[c] = ((sync_q[c] ^ active_low) & ~mask[c]) | sw_req[c];
    end
endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick
    import arb_pkg::*;
(
    input  ch_vec_t   pend,
    input  prio_cfg_t cfg,
    output ch_idx_t   pick,
    output logic      any
);
    ch_idx_t start;
    ch_idx_t cand;

    always_comb begin
        start = cfg.rotate ? ch_idx_t'(cfg.last + 1'b1) : '0;
        pick  = '0;
        any   = 1'b0;
        cand  = '0;
        for (int k = 0; k < CH_N; k++) begin
            cand = ch_idx_t'(start + ch_idx_t'(k));
            if (!any && pend[cand]) begin
                pick = cand;
                any  = 1'b1;
            end
        end
    end

    always_comb begin
        if (any) begin
            a_pick_pending_r12: assert (pend[pick])
                else $error("picked channel not pending");
        end
    end
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] hw_req_i,
    input  logic [3:0] mask_i,
    input  logic [3:0] sw_req_i,
    input  logic       req_active_low_i,
    input  logic       ack_active_high_i,
    input  logic       rotate_en_i,
    input  logic       ctrl_disable_i,
    input  logic       grant_i,
    input  logic       done_i,
    output logic       hold_req_o,
    output logic       win_valid_o,
    output logic [1:0] win_idx_o,
    output logic [3:0] ack_o
);
    arb_state_e state_q;
    ch_idx_t    win_q, last_q;
    ch_vec_t    pend, ack_act;
    ch_idx_t    pick;
    logic       any;
    prio_cfg_t  cfg;

    arb_req_qual u_qual (
        .clk        (clk),
        .rst        (rst),
        .raw_req    (hw_req_i),
        .active_low (req_active_low_i),
        .mask       (mask_i),
        .sw_req     (sw_req_i),
        .pend       (pend)
    );

    assign cfg = '{rotate: rotate_en_i, last: last_q};

    arb_prio_pick u_pick (
        .pend (pend),
        .cfg  (cfg),
        .pick (pick),
        .any  (any)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            win_q   <= '0;
            last_q  <= ch_idx_t'(CH_N - 1);
        end else begin
            unique case (state_q)
                ST_IDLE:  if (!ctrl_disable_i && any) state_q <= ST_HOLD;
                ST_HOLD: begin
                    if (ctrl_disable_i || !any) begin
                        state_q <= ST_IDLE;
                    end else if (grant_i) begin
                        win_q   <= pick;
                        state_q <= ST_SERVE;
                    end
                end
                ST_SERVE: if (done_i) begin
                    last_q  <= win_q;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign hold_req_o  = (state_q != ST_IDLE);
    assign win_valid_o = (state_q == ST_SERVE);
    assign win_idx_o   = win_q;
    assign ack_act     = win_valid_o ? idx_to_onehot(win_q) : '0;
    assign ack_o       = ack_active_high_i ? ack_act : ~ack_act;

    p_locked_winner_r7: assert property (@(posedge clk) disable iff (rst)
        (win_valid_o && !done_i) |=> (win_valid_o && $stable(win_idx_o)))
        else $error("winner changed during service");

    p_serve_needs_hold_r11: assert property (@(posedge clk) disable iff (rst)
        win_valid_o |-> hold_req_o)
        else $error("service without hold request");

    p_release_after_done_r11: assert property (@(posedge clk) disable iff (rst)
        (win_valid_o && done_i) |=> !hold_req_o)
        else $error("bus not released after done");

    p_disable_blocks_r10: assert property (@(posedge clk) disable iff (rst)
        (!hold_req_o && ctrl_disable_i) |=> !hold_req_o)
        else $error("service started while disabled");

    p_ack_single_r9: assert property (@(posedge clk) disable iff (rst)
        win_valid_o |-> $countones(ack_o ^ {CH_N{~ack_active_high_i}}) == 1)
        else $error("acknowledge not single");
endmodule

// File: tb/sim_dma_chan_arbiter.sv
module sim_dma_chan_arbiter;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] hw = '0, mask = '0, sw = '0;
    logic req_low = 1'b0, ack_hi = 1'b0, rot = 1'b0, dis = 1'b0;
    logic grant = 1'b0, done = 1'b0;
    logic hold, valid;
    logic [1:0] idx;
    logic [3:0] ack;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dma_chan_arbiter u0 (
        .clk(clk), .rst(rst), .hw_req_i(hw), .mask_i(mask), .sw_req_i(sw),
        .req_active_low_i(req_low), .ack_active_high_i(ack_hi),
        .rotate_en_i(rot), .ctrl_disable_i(dis), .grant_i(grant),
        .done_i(done), .hold_req_o(hold), .win_valid_o(valid),
        .win_idx_o(idx), .ack_o(ack)
    );

    // behavioural reference model
    logic [3:0] m_s1, m_s2, m_pend;
    int m_st, m_win, m_last;

    function automatic int mpick(logic [3:0] p, bit r, int last);
        int s;
        s = r ? (last + 1) % 4 : 0;
        for (int k = 0; k < 4; k++)
            if (p[(s + k) % 4]) return (s + k) % 4;
        return 0;
    endfunction

    always @(posedge clk) begin
        m_pend = ((m_s2 ^ {4{req_low}}) & ~mask) | sw;
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_st = 0; m_win = 0; m_last = 3;
        end else begin
            case (m_st)
                0: if (!dis && m_pend != 0) m_st = 1;
                1: if (dis || m_pend == 0) m_st = 0;
                   else if (grant) begin m_win = mpick(m_pend, rot, m_last); m_st = 2; end
                default: if (done) begin m_last = m_win; m_st = 0; end
            endcase
            m_s2 = m_s1;
            m_s1 = hw;
        end
    end

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic [3:0] ea;
            ea = (m_st == 2) ? (4'b1 << m_win) : 4'b0;
            if (!ack_hi) ea = ~ea;
            chk(32'(hold), 32'(m_st != 0), "R11 R2 hold_req");
            chk(32'(valid), 32'(m_st == 2), "R7 win_valid");
            if (m_st == 2) chk(32'(idx), 32'(m_win), "R5 R6 win_idx");
            chk(32'(ack), 32'(ea), "R9 ack");
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic serve(input int exp_win, input string tag);
        grant = 1'b1; cyc(1); grant = 1'b0;
        chk(32'(idx), 32'(exp_win), tag);
        cyc(2);
        done = 1'b1; cyc(1); done = 1'b0;
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        // R1 reset state
        chk(32'(hold), 0, "R1 hold after reset");
        chk(32'(ack), 32'hF, "R1 ack inactive after reset");
        // R2 latency, R5 fixed pick
        hw = 4'b1010;
        cyc(2); chk(32'(hold), 0, "R2 hold too early");
        cyc(1); chk(32'(hold), 1, "R2 hold on third edge");
        grant = 1'b1; cyc(1); grant = 1'b0;
        chk(32'(idx), 1, "R5 fixed lowest wins");
        chk(32'(ack), 32'hD, "R9 active-low ack");
        // R7 lock while a higher request appears
        hw = 4'b1011; cyc(4);
        chk(32'(idx), 1, "R7 winner locked");
        done = 1'b1; cyc(1); done = 1'b0;
        chk(32'(hold), 0, "R11 released after done");
        hw = '0; cyc(4);
        // R3 mask
        mask = 4'b0001; hw = 4'b0001; cyc(5);
        chk(32'(hold), 0, "R3 masked ignored");
        // R4 software bypasses mask
        hw = '0; mask = 4'hF; sw = 4'b0100; cyc(1);
        chk(32'(hold), 1, "R4 sw request raises hold");
        serve(2, "R4 sw winner");
        sw = '0; mask = '0; cyc(3);
        // R6 rotating walk: last served was 2
        rot = 1'b1; hw = 4'hF; cyc(3);
        serve(3, "R6 rotate first");
        cyc(1); serve(0, "R6 rotate second");
        cyc(1); serve(1, "R6 rotate third");
        cyc(1); serve(2, "R6 rotate fourth");
        hw = '0; rot = 1'b0; cyc(4);
        // R8 request polarity, R9 active-high ack
        req_low = 1'b1; hw = 4'hF; cyc(4);
        chk(32'(hold), 0, "R8 high lines idle when active low");
        hw = 4'b1011; ack_hi = 1'b1; cyc(3);
        chk(32'(hold), 1, "R8 low line requests");
        grant = 1'b1; cyc(1); grant = 1'b0;
        chk(32'(idx), 2, "R8 winner");
        chk(32'(ack), 32'h4, "R9 active-high ack");
        done = 1'b1; cyc(1); done = 1'b0;
        hw = 4'hF; cyc(4);
        req_low = 1'b0; hw = '0; ack_hi = 1'b0; cyc(4);
        // R10 disable
        dis = 1'b1; sw = 4'b0001; cyc(3);
        chk(32'(hold), 0, "R10 disabled no hold");
        dis = 1'b0; cyc(1);
        chk(32'(hold), 1, "R10 enabled hold");
        dis = 1'b1; cyc(1);
        chk(32'(hold), 0, "R10 pending hold dropped");
        dis = 1'b0; sw = '0; cyc(2);
        // R12 withdrawal and evaluation at grant
        sw = 4'b1000; cyc(1);
        sw = '0; cyc(1);
        chk(32'(hold), 0, "R12 withdrawn request drops hold");
        sw = 4'b1000; cyc(2);
        sw = 4'b1010;
        serve(1, "R12 pick at grant");
        sw = '0; cyc(3);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule